// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the per-port status and control byte of a high-speed USB host root port. It tracks whether a device is attached, whether the port is enabled, whether an overcurrent condition is present, and whether resume signalling is being driven. Each of these fields has a matching change flag where the specification calls for one. The change flags are sticky, and software clears them by writing 1.

Hardware events arrive on a small set of port-state inputs:

- Connect and overcurrent are levels.
- J-to-K detection while suspended, high-speed reset result and fault disable are single-cycle pulses.
- High-speed idle reached is a level or a pulse.

Software reaches the register through a single-cycle write strobe with a byte of write data. The byte is read back combinationally.

A one-cycle pulse asks the global status logic to raise its port-change-detect flag. A resume timer watches the return to high-speed idle after software ends resume signalling.

Top module: `usb_rootport_sc`

Field layout of the byte:

| Bit | Field | Access |
|-----|-------|--------|
| 0 | enabled | write 0 clears, write 1 ignored |
| 1 | enable-change | write 1 to clear |
| 2 | connected | read only |
| 3 | connect-change | write 1 to clear |
| 4 | resume | read/write |
| 5 | overcurrent-active | read only |
| 6 | overcurrent-change | write 1 to clear |
| 7 | reserved | reads 0 |

## Requirements
- R1: Bit 2 (connected) takes the value of `ev_connect` one clock after it is sampled. Bit 3 (connect-change) sets whenever the sampled connect input differs from bit 2, and stays set if it is already set. Writing 1 to bit 3 clears it.
- R2: Bit 5 (overcurrent-active) follows `ev_overcur` one clock later and returns to 0 by itself when the input drops. Bit 6 (overcurrent-change) sets on every change of bit 5. Writing 1 to bit 6 clears it.
- R3: Bit 0 (enabled) becomes 1 only on a clock where `ev_reset_hs` is high and `ev_fault` is low. A software write with bit 0 = 1 never sets it.
- R4: Bit 0 clears on a write with bit 0 = 0 unless `ev_reset_hs` is high in the same clock. `ev_fault` always clears it. Bit 1 (enable-change) sets only when `ev_fault` hits an enabled port, never on a software disable. Writing 1 to bit 1 clears it.
- R5: `ev_jk_suspended` sets bit 4 (resume). If bit 4 was 0, `pcd_pulse` is high for exactly the following clock.
- R6: A write with bit 4 = 1 while bit 4 is 0 sets bit 4 and never raises `pcd_pulse`.
- R7: A write with bit 4 = 0 while bit 4 is 1 starts a drain. Bit 4 stays 1 until the clock on which `ev_hs_idle` is sampled high during the drain, and reads 0 after that edge.
- R8: If a drain lasts `TIMEOUT_CYC` clocks without `ev_hs_idle`, `resume_timeout` rises `TIMEOUT_CYC` clocks after the write that started the drain. It falls on the edge where the drain ends.
- R9: While `port_pwr` is 0, `rd_data` reads 0x00. After reset every field is 0 and `pcd_pulse` and `resume_timeout` are low.
- R10: When a hardware set event and a write-1-to-clear hit the same change bit in the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pwr | input | 1 | Port power; 0 forces reads to zero |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read of the register byte |
| ev_connect | input | 1 | Device presence level |
| ev_overcur | input | 1 | Overcurrent level |
| ev_jk_suspended | input | 1 | J-to-K seen while suspended (pulse) |
| ev_reset_hs | input | 1 | Reset sequence found a high-speed device (pulse) |
| ev_fault | input | 1 | Fault disables the port (pulse) |
| ev_hs_idle | input | 1 | Port reached high-speed idle |
| pcd_pulse | output | 1 | Request to raise the global port-change-detect flag |
| resume_timeout | output | 1 | Resume drain exceeded its cycle budget |

## Verification
Random stimulus toggles the connect and overcurrent levels while random writes hit the change bits. This separates hardware sets from software clears, and same-cycle collisions show that the set takes priority. Rare fault, reset-result and J-to-K pulses mixed with random resume writes separate hardware-caused resume from software-caused resume through the presence or absence of `pcd_pulse`. Directed cases cover:

- a write of 1 to the enable bit on a disabled port;
- a drain that ends on `ev_hs_idle`;
- a drain that runs past the timeout budget;
- reads with port power off.

// File: rtl/usb_rootport_pkg.sv
package usb_rootport_pkg;
    localparam int unsigned REG_W = 8;

    // field positions inside the register byte
    localparam int unsigned B_EN       = 0;
    localparam int unsigned B_EN_CHG   = 1;
    localparam int unsigned B_CONN     = 2;
    localparam int unsigned B_CONN_CHG = 3;
    localparam int unsigned B_RESUME   = 4;
    localparam int unsigned B_OC       = 5;
    localparam int unsigned B_OC_CHG   = 6;

    // index of each sticky change flag inside the change bank
    localparam int unsigned CHG_N    = 3;
    localparam int unsigned CHG_EN   = 0;
    localparam int unsigned CHG_CONN = 1;
    localparam int unsigned CHG_OC   = 2;

    typedef struct packed {
        logic conn;
        logic oc;
        logic en;
        logic resume;
        logic drain;
        logic pcd;
    } rp_state_t;
endpackage

// File: rtl/rp_w1c_bank.sv
module rp_w1c_bank #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // hardware set has priority over the software clear
        always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= flag_d[i];
        end
    end

    assign q_o = flag_q;
endmodule

// File: rtl/rp_resume_timer.sv
module rp_resume_timer #(
    parameter int unsigned LIMIT = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic stop_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             exp_d, exp_q;

    always_comb begin
        cnt_d = '0;
        exp_d = 1'b0;
        if (run_i && !stop_i) begin
            cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
            exp_d = exp_q | (cnt_q == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            exp_q <= exp_d;
        end
    end

    assign expired_o = exp_q;
endmodule

// File: rtl/usb_rootport_sc.sv
module usb_rootport_sc
    import usb_rootport_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 120000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_pwr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_connect,
    input  logic             ev_overcur,
    input  logic             ev_jk_suspended,
    input  logic             ev_reset_hs,
    input  logic             ev_fault,
    input  logic             ev_hs_idle,
    output logic             pcd_pulse,
    output logic             resume_timeout
);
    rp_state_t        cur_q, nxt_d;
    logic [CHG_N-1:0] chg_set, chg_clr, chg_q;
    logic [REG_W-1:0] field_w;

    // change-flag events and software clears
    always_comb begin
        chg_set           = '0;
        chg_clr           = '0;
        chg_set[CHG_CONN] = ev_connect != cur_q.conn;
        chg_set[CHG_OC]   = ev_overcur != cur_q.oc;
        chg_set[CHG_EN]   = ev_fault & cur_q.en;
        chg_clr[CHG_CONN] = wr_en & wr_data[B_CONN_CHG];
        chg_clr[CHG_OC]   = wr_en & wr_data[B_OC_CHG];
        chg_clr[CHG_EN]   = wr_en & wr_data[B_EN_CHG];
    end

    // next-state computation
    always_comb begin
        nxt_d      = cur_q;
        nxt_d.conn = ev_connect;
        nxt_d.oc   = ev_overcur;
        nxt_d.pcd  = 1'b0;

        if (ev_fault)                     nxt_d.en = 1'b0;
        else if (ev_reset_hs)             nxt_d.en = 1'b1;
        else if (wr_en && !wr_data[B_EN]) nxt_d.en = 1'b0;

        if (ev_jk_suspended) begin
            nxt_d.resume = 1'b1;
            nxt_d.drain  = 1'b0;
            nxt_d.pcd    = ~cur_q.resume;
        end else if (wr_en && wr_data[B_RESUME] && !cur_q.resume) begin
            nxt_d.resume = 1'b1;
        end else if (cur_q.drain && ev_hs_idle) begin
            nxt_d.resume = 1'b0;
            nxt_d.drain  = 1'b0;
        end else if (wr_en && !wr_data[B_RESUME] && cur_q.resume && !cur_q.drain) begin
            nxt_d.drain  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    rp_w1c_bank #(.N(CHG_N)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (chg_set),
        .clr_i (chg_clr),
        .q_o   (chg_q)
    );

    rp_resume_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (cur_q.drain),
        .stop_i    (ev_hs_idle | ev_jk_suspended),
        .expired_o (resume_timeout)
    );

    always_comb begin
        field_w             = '0;
        field_w[B_EN]       = cur_q.en;
        field_w[B_EN_CHG]   = chg_q[CHG_EN];
        field_w[B_CONN]     = cur_q.conn;
        field_w[B_CONN_CHG] = chg_q[CHG_CONN];
        field_w[B_RESUME]   = cur_q.resume;
        field_w[B_OC]       = cur_q.oc;
        field_w[B_OC_CHG]   = chg_q[CHG_OC];
        rd_data             = port_pwr ? field_w : '0;
    end

    assign pcd_pulse = cur_q.pcd;
endmodule

// File: rtl/usb_rootport_chk.sv
module usb_rootport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       port_pwr,
    input logic [7:0] rd_data,
    input logic       ev_connect,
    input logic       ev_jk_suspended,
    input logic       ev_reset_hs,
    input logic       ev_fault,
    input logic       pcd_pulse,
    input logic       resume_timeout,
    input logic       conn_i,
    input logic       conn_chg_i,
    input logic       en_i,
    input logic       en_chg_i,
    input logic       resume_i
);
    // R5
    pcd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcd_pulse |-> $past(ev_jk_suspended));

    // R9
    pwr_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_pwr |-> (rd_data == 8'h00));

    // R3
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> $past(ev_reset_hs));

    // R1
    conn_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_connect != conn_i) |=> conn_chg_i);

    // R4
    fault_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fault && en_i) |=> (en_chg_i && !en_i));

    // R8
    timeout_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_timeout |-> resume_i);
endmodule

bind usb_rootport_sc usb_rootport_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .port_pwr        (port_pwr),
    .rd_data         (rd_data),
    .ev_connect      (ev_connect),
    .ev_jk_suspended (ev_jk_suspended),
    .ev_reset_hs     (ev_reset_hs),
    .ev_fault        (ev_fault),
    .pcd_pulse       (pcd_pulse),
    .resume_timeout  (resume_timeout),
    .conn_i          (cur_q.conn),
    .conn_chg_i      (chg_q[1]),
    .en_i            (cur_q.en),
    .en_chg_i        (chg_q[0]),
    .resume_i        (cur_q.resume)
);

// File: tb/usb_rootport_sc_bench.sv
module usb_rootport_sc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_pwr = 1'b1, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ev_connect = 0, ev_overcur = 0, ev_jk_suspended = 0;
    logic       ev_reset_hs = 0, ev_fault = 0, ev_hs_idle = 0;
    logic       pcd_pulse, resume_timeout;

    int checks = 0, failures = 0;
    bit m_conn, m_cc, m_en, m_ec, m_oc, m_occ, m_res, m_drain, m_pcd, m_to;
    int m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_rootport_sc #(.TIMEOUT_CYC(LIM)) u_usb_rootport_sc (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        if (!port_pwr) return 8'h00;
        return {1'b0, m_occ, m_oc, m_res, m_cc, m_conn, m_ec, m_en};
    endfunction

    // apply one cycle of stimulus, advance the reference model, compare
    task automatic step(bit c, bit o, bit jk, bit rh, bit f, bit idle, bit we, logic [7:0] wd);
        bit ncc, nocc, nec, nen, nres, ndrain, npcd, nto;
        int ncnt;
        @(negedge clk);
        ev_connect = c; ev_overcur = o; ev_jk_suspended = jk; ev_reset_hs = rh;
        ev_fault = f; ev_hs_idle = idle; wr_en = we; wr_data = wd;
        @(posedge clk);
        ncc  = (c != m_conn) || (m_cc && !(we && wd[3]));
        nocc = (o != m_oc) || (m_occ && !(we && wd[6]));
        nec  = (f && m_en) || (m_ec && !(we && wd[1]));
        nen  = f ? 1'b0 : rh ? 1'b1 : (we && !wd[0]) ? 1'b0 : m_en;
        nres = m_res; ndrain = m_drain; npcd = 1'b0;
        if (jk) begin nres = 1; ndrain = 0; npcd = !m_res; end
        else if (we && wd[4] && !m_res) nres = 1;
        else if (m_drain && idle) begin nres = 0; ndrain = 0; end
        else if (we && !wd[4] && m_res && !m_drain) ndrain = 1;
        if (m_drain && !(idle || jk)) begin
            ncnt = (m_cnt == LIM-1) ? m_cnt : m_cnt + 1;
            nto  = m_to || (m_cnt == LIM-1);
        end else begin
            ncnt = 0; nto = 0;
        end
        m_conn = c; m_oc = o; m_cc = ncc; m_occ = nocc; m_ec = nec; m_en = nen;
        m_res = nres; m_drain = ndrain; m_pcd = npcd; m_cnt = ncnt; m_to = nto;
        #1;
        wr_en = 1'b0;
        chk("R1 connect fields",  int'(rd_data[3:2]), int'(port_pwr ? {m_cc, m_conn} : 2'b00));
        chk("R2 overcurrent fields", int'(rd_data[6:5]), int'(port_pwr ? {m_occ, m_oc} : 2'b00));
        chk("R3/R4 enable fields", int'(rd_data[1:0]), int'(port_pwr ? {m_ec, m_en} : 2'b00));
        chk("R7 resume bit", int'(rd_data[4]), int'(port_pwr & m_res));
        chk("R5/R6 pcd_pulse", int'(pcd_pulse), int'(m_pcd));
        chk("R8 resume_timeout", int'(resume_timeout), int'(m_to));
        chk("R9 whole byte", int'(rd_data), int'(exp_rd()));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 reset rd_data", int'(rd_data), 0);
        chk("R9 reset pcd", int'(pcd_pulse), 0);
        chk("R9 reset timeout", int'(resume_timeout), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3: write 1 to enable on a disabled port has no effect
        step(0,0,0,0,0,0,1,8'h01);
        chk("R3 write1 ignored", int'(rd_data[0]), 0);
        // R3: reset result enables
        step(0,0,0,1,0,0,0,8'h00);
        chk("R3 enabled by reset_hs", int'(rd_data[0]), 1);
        // R4: software disable, no change flag
        step(0,0,0,0,0,0,1,8'h00);
        chk("R4 sw disable no change", int'(rd_data[1:0]), 0);
        // R4: fault disable sets change
        step(0,0,0,1,0,0,0,8'h00);
        step(0,0,0,0,1,0,0,8'h00);
        chk("R4 fault sets change", int'(rd_data[1:0]), 2);
        step(0,0,0,0,0,0,1,8'h02);
        // R10: connect toggles while software clears connect-change
        step(1,0,0,0,0,0,0,8'h00);
        step(0,0,0,0,0,0,1,8'h08);
        chk("R10 set beats clear", int'(rd_data[3]), 1);
        step(0,0,0,0,0,0,1,8'h08);
        chk("R1 cleared by write 1", int'(rd_data[3]), 0);
        // R6: software resume, no pcd
        step(0,0,0,0,0,0,1,8'h10);
        chk("R6 no pcd on sw resume", int'(pcd_pulse), 0);
        // R7: clear starts drain, bit stays until idle
        step(0,0,0,0,0,0,1,8'h00);
        repeat (5) step(0,0,0,0,0,0,0,8'h00);
        chk("R7 resume held", int'(rd_data[4]), 1);
        step(0,0,0,0,0,1,0,8'h00);
        chk("R7 resume dropped at idle", int'(rd_data[4]), 0);
        // R5: hardware J-to-K raises pcd
        step(0,0,1,0,0,0,0,8'h00);
        chk("R5 pcd pulse", int'(pcd_pulse), 1);
        step(0,0,0,0,0,0,0,8'h00);
        chk("R5 pcd one cycle", int'(pcd_pulse), 0);
        // R8: drain without idle times out after LIM cycles
        step(0,0,0,0,0,0,1,8'h00);
        repeat (LIM - 1) step(0,0,0,0,0,0,0,8'h00);
        chk("R8 not yet timed out", int'(resume_timeout), 0);
        step(0,0,0,0,0,0,0,8'h00);
        chk("R8 timed out", int'(resume_timeout), 1);
        step(0,0,0,0,0,1,0,8'h00);
        chk("R8 timeout cleared", int'(resume_timeout), 0);
        // R9: power off reads zero
        step(1,1,0,1,0,0,0,8'h00);
        port_pwr = 1'b0;
        #1 chk("R9 power off zero", int'(rd_data), 0);
        port_pwr = 1'b1;
        // R2: overcurrent drops by itself
        step(1,0,0,0,0,0,0,8'h00);
        chk("R2 oc dropped", int'(rd_data[6:5]), 2);

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            bit c, o, jk, rh, f, idle, we;
            logic [7:0] wd;
            c    = ($urandom % 8) == 0 ? !m_conn : m_conn;
            o    = ($urandom % 12) == 0 ? !m_oc : m_oc;
            jk   = ($urandom % 40) == 0;
            rh   = ($urandom % 20) == 0;
            f    = ($urandom % 25) == 0;
            idle = ($urandom % 30) == 0;
            we   = ($urandom % 4) == 0;
            wd   = 8'($urandom);
            port_pwr = ($urandom % 16) != 0;
            step(c, o, jk, rh, f, idle, we, wd);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule